// File: doc/BRIEF.md
# Flash Write Protection Controller

This block is the gatekeeper for modifying operations on a 128 KB serial flash array. The array is four 32 KB sectors, each of 128 pages of 256 bytes. The command decoder hands it one decoded request at a time: an operation code, a target byte address and, for a status write, the new status byte. The block answers with a one-cycle grant or deny pulse. It holds the write-enable latch, a two-bit block-protect field and a protect-pin-enable bit (`wpen`). Together with the active-low write-protect pin, these decide whether a program, a sector erase or a status write may proceed.

A status write that is allowed is not applied at once. It stays pending until chip select is released, and the new contents are committed on that release. While it waits, a falling edge on the protect pin with chip select still low cancels it, but only when `wpen` is set. Once the commit has happened, the pin no longer affects it. A sticky error flag records any attempt to program or erase a protected location.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, `status`, `err_flag`, `grant`, `deny` and `sr_commit` are all zero.
- R2: Operation codes are 1 = set latch, 2 = clear latch, 3 = program, 4 = sector erase and 5 = status write. Codes 0, 6 and 7 change nothing. `status` bit 1 shows the write-enable latch; bits 3:2 show the block-protect field; bit 7 shows `wpen`; bit 0 shows a pending status write; bits 6:4 read zero.
- R3: A program or erase request that arrives while the latch is clear gives `deny` on the next clock, no `grant`, and leaves `err_flag` unchanged.
- R4: The protect field selects the locked range: 00 locks nothing, 01 locks addresses 98304 and up, 10 locks addresses 65536 and up, and 11 locks the whole array. With the latch set, a program or erase inside the locked range gives `deny` on the next clock, sets `err_flag` until reset, and clears the latch.
- R5: With the latch set, a program or erase outside the locked range gives `grant` on the next clock and clears the latch.
- R6: A status write request is denied on the next clock, and the latch is cleared, if the latch is clear, or if `wpen` is 1 and `wp_n` is low.
- R7: An accepted status write sets `status` bit 0. All requests are ignored while it is pending. It commits on the first clock that samples `cs_n` high: `sr_commit` pulses, bit 7 and bits 3:2 of the request data are loaded into `wpen` and the protect field, and the latch clears.
- R8: While a status write is pending and `wpen` is 1, a fall of `wp_n` sampled while `cs_n` is low aborts it. `deny` pulses, nothing is committed, and the latch clears.
- R9: When `wpen` is 0, `wp_n` has no effect: a status write succeeds with the pin held low, and a fall of the pin does not abort it.
- R10: If the `wp_n` fall and the `cs_n` release are sampled on the same clock, the status write commits.
- R11: At most one of `grant`, `deny` and `sr_commit` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| wp_n | input | 1 | Write-protect pin, active low, synchronous to clk |
| req_valid | input | 1 | Decoded request present this cycle |
| req_op | input | 3 | Operation code (R2) |
| req_addr | input | 17 | Target byte address |
| req_data | input | 8 | New status byte for a status write |
| grant | output | 1 | Operation allowed (one-cycle pulse) |
| deny | output | 1 | Operation refused or aborted (one-cycle pulse) |
| sr_commit | output | 1 | Status contents committed (one-cycle pulse) |
| err_flag | output | 1 | Sticky protection violation flag |
| status | output | 8 | Status byte (R2) |

## Verification
The bench probes the exact edges of each locked range (98303/98304 and 65535/65536), where an off-by-one compare would either grant a write into a locked sector or refuse a legal one. It drives a protect-pin fall while a status write is pending, both with `wpen` set and with it clear. A design that ignores `wpen` would abort writes it should keep, or commit writes it should abort. It lines up the pin fall with the chip-select release on the same clock, where a wrong priority would drop a write whose cycle had already begun. It also sends requests during a pending status write, and sends unused codes, to catch stray changes to the latch.

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 32768,
  parameter int ADDR_W       = $clog2(SECTORS * SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              grant,
  output logic              deny,
  output logic              sr_commit,
  output logic              err_flag,
  output logic [7:0]        status
);

  localparam logic [2:0] OP_SET  = 3'd1;
  localparam logic [2:0] OP_CLR  = 3'd2;
  localparam logic [2:0] OP_PROG = 3'd3;
  localparam logic [2:0] OP_ERAS = 3'd4;
  localparam logic [2:0] OP_WRST = 3'd5;

  localparam longint TOTAL = longint'(SECTORS) * SECTOR_BYTES;
  localparam logic [ADDR_W:0] LIM_QTR  = (ADDR_W+1)'(TOTAL - TOTAL / 4);
  localparam logic [ADDR_W:0] LIM_HALF = (ADDR_W+1)'(TOTAL / 2);

  logic       wel, wpen, pend, cs_q, wp_q;
  logic [1:0] bp;
  logic [7:0] nd;

  wire cs_rise = cs_n & ~cs_q;
  wire wp_fall = wp_q & ~wp_n;
  wire [ADDR_W:0] a_ext = {1'b0, req_addr};
  wire locked = (bp == 2'b11) ||
                (bp == 2'b10 && a_ext >= LIM_HALF) ||
                (bp == 2'b01 && a_ext >= LIM_QTR);
  wire wr_op = (req_op == OP_PROG) || (req_op == OP_ERAS);

  assign status = {wpen, 3'b000, bp, wel, pend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; wpen <= 1'b0; bp <= 2'b00; pend <= 1'b0; nd <= 8'h00;
      cs_q <= 1'b1; wp_q <= 1'b1;
      grant <= 1'b0; deny <= 1'b0; sr_commit <= 1'b0; err_flag <= 1'b0;
    end else begin
      cs_q <= cs_n;
      wp_q <= wp_n;
      grant <= 1'b0;
      deny <= 1'b0;
      sr_commit <= 1'b0;
      if (pend) begin
        if (cs_rise) begin
          wpen <= nd[7];
          bp <= nd[3:2];
          sr_commit <= 1'b1;
          pend <= 1'b0;
          wel <= 1'b0;
        end else if (wp_fall && wpen && !cs_n) begin
          deny <= 1'b1;
          pend <= 1'b0;
          wel <= 1'b0;
        end
      end else if (req_valid) begin
        case (req_op)
          OP_SET: wel <= 1'b1;
          OP_CLR: wel <= 1'b0;
          OP_PROG, OP_ERAS: begin
            if (!wel) deny <= 1'b1;
            else if (locked) begin
              deny <= 1'b1; err_flag <= 1'b1; wel <= 1'b0;
            end else begin
              grant <= 1'b1; wel <= 1'b0;
            end
          end
          OP_WRST: begin
            if (!wel || (wpen && !wp_n)) begin
              deny <= 1'b1; wel <= 1'b0;
            end else begin
              pend <= 1'b1; nd <= req_data;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant, deny, sr_commit}));

  a_r3_latch_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pend && wr_op && !wel) |=> (deny && !grant));

  a_r5_grant_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !wel);

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r6_pin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pend && req_op == OP_WRST && wpen && !wp_n) |=> (deny && !pend));

  a_r9_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !wpen && !cs_n) |=> !deny);

  a_r7_commit_state: assert property (@(posedge clk) disable iff (!rst_n)
    sr_commit |-> (!wel && !pend && cs_q));

endmodule

// File: tb/tb_flash_wp_ctrl.sv
module tb_flash_wp_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, wp_n = 1'b1, req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic grant, deny, sr_commit, err_flag;
  logic [7:0] status;

  flash_wp_ctrl dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .grant(grant), .deny(deny), .sr_commit(sr_commit), .err_flag(err_flag), .status(status));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_wel = 0, m_wpen = 0, m_err = 0, m_pend = 0;
  logic [1:0] m_bp = 0;

  function automatic bit locked(logic [1:0] bp, int addr);
    return bp == 2'd3 || (bp == 2'd2 && addr >= 65536) || (bp == 2'd1 && addr >= 98304);
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_wpen, 3'b000, m_bp, m_wel, m_pend};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic outs(string tag, bit eg, bit ed, bit ec);
    chk({tag, " grant"}, grant, eg);
    chk({tag, " deny"}, deny, ed);
    chk({tag, " commit"}, sr_commit, ec);
    chk({tag, " err"}, err_flag, m_err);
    chk({tag, " status"}, status, exp_status());
    chk("R11 single outcome", int'(grant) + int'(deny) + int'(sr_commit) <= 1, 1);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic req(logic [2:0] op, int addr, string tag);
    bit eg = 0, ed = 0;
    req_valid = 1; req_op = op; req_addr = 17'(addr);
    step();
    req_valid = 0;
    case (op)
      3'd1: m_wel = 1;
      3'd2: m_wel = 0;
      3'd3, 3'd4: begin
        if (!m_wel) ed = 1;
        else if (locked(m_bp, addr)) begin ed = 1; m_err = 1; m_wel = 0; end
        else begin eg = 1; m_wel = 0; end
      end
      default: ;
    endcase
    outs(tag, eg, ed, 0);
  endtask

  // mode 0: plain, 1: pin falls before release, 2: pin falls with release
  task automatic wrsr(logic [7:0] d, bit wp0, int mode, string tag);
    bit abort;
    wp_n = wp0; step();
    cs_n = 0; step();
    req_valid = 1; req_op = 3'd5; req_data = d;
    step();
    req_valid = 0;
    if (!m_wel || (m_wpen && !wp0)) begin
      m_wel = 0; outs({tag, " refuse"}, 0, 1, 0);
      cs_n = 1; step(); outs({tag, " release"}, 0, 0, 0);
    end else begin
      m_pend = 1; outs({tag, " pending"}, 0, 0, 0);
      req_valid = 1; req_op = 3'd2; step(); req_valid = 0;
      outs({tag, " R7 ignored while pending"}, 0, 0, 0);
      abort = 0;
      if (mode == 1 && wp0) begin
        wp_n = 0; step();
        if (m_wpen) begin abort = 1; m_pend = 0; m_wel = 0; end
        outs({tag, " pin fall"}, 0, abort, 0);
      end
      cs_n = 1;
      if (mode == 2) wp_n = 0;
      step();
      if (!abort) begin
        m_pend = 0; m_wel = 0; m_wpen = d[7]; m_bp = d[3:2];
        outs({tag, " commit"}, 0, 0, 1);
      end else outs({tag, " no commit"}, 0, 0, 0);
    end
    wp_n = 1; step();
    outs({tag, " settle"}, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    outs("R1 reset", 0, 0, 0);
    rst_n = 1; step();
    outs("R1 after release", 0, 0, 0);

    req(3'd3, 100, "R3 program without latch");
    req(3'd4, 100, "R3 erase without latch");
    req(3'd1, 0, "R2 set latch");
    req(3'd2, 0, "R2 clear latch");
    req(3'd1, 0, "R2 set latch again");
    req(3'd0, 0, "R2 unused code 0");
    req(3'd6, 0, "R2 unused code 6");
    req(3'd7, 0, "R2 unused code 7");
    req(3'd3, 131071, "R5 program unlocked top");

    req(3'd1, 0, "R2 set");
    wrsr(8'h04, 1, 0, "R7 bp01");
    req(3'd1, 0, "R2 set"); req(3'd3, 98303, "R5 below quarter");
    req(3'd1, 0, "R2 set"); req(3'd3, 98304, "R4 quarter edge");
    req(3'd1, 0, "R2 set"); req(3'd4, 0, "R4 err stays after grant");
    req(3'd1, 0, "R2 set");
    wrsr(8'h08, 1, 0, "R7 bp10");
    req(3'd1, 0, "R2 set"); req(3'd3, 65535, "R5 below half");
    req(3'd1, 0, "R2 set"); req(3'd4, 65536, "R4 half edge");
    req(3'd1, 0, "R2 set");
    wrsr(8'h0C, 0, 0, "R9 wpen0 pin low bp11");
    req(3'd1, 0, "R2 set"); req(3'd3, 0, "R4 whole array");

    wrsr(8'h00, 1, 0, "R6 latch clear");
    req(3'd1, 0, "R2 set");
    wrsr(8'h00, 1, 1, "R9 fall ignored wpen0");
    req(3'd1, 0, "R2 set");
    wrsr(8'h80, 1, 0, "R7 set wpen");
    req(3'd1, 0, "R2 set");
    wrsr(8'h84, 0, 0, "R6 pin low wpen1");
    req(3'd1, 0, "R2 set");
    wrsr(8'h00, 1, 1, "R8 abort");
    req(3'd1, 0, "R2 set");
    wrsr(8'h88, 1, 2, "R10 same cycle");
    req(3'd1, 0, "R2 set");
    wrsr(8'h00, 1, 0, "R7 clear all");

    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 10);
      int a = int'($urandom % 131072);
      case (r)
        0, 1: req(3'd1, a, "R2 rnd set");
        2: req(3'd2, a, "R2 rnd clear");
        3, 4: req(3'd3, a, "R4 R5 rnd program");
        5: req(3'd4, a, "R4 R5 rnd erase");
        6: wrsr(8'($urandom), 1'($urandom), int'($urandom % 3), "R7 R8 R9 rnd wrsr");
        7: req(3'($urandom % 2 ? 6 : 7), a, "R2 rnd unused");
        default: begin req(3'd1, 0, "R2 rnd set"); req(3'd3, a, "R4 R5 rnd program"); end
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule